// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of hardware token flags that two independent ports, called left and right, use to arbitrate shared resources. A port reaches the bank when its RAM chip-enable is inactive (high) and its semaphore select is active (low). The low address bits then choose one flag. A write carries one meaningful data bit. Bit 0 equal to 0 asks for the token, and bit 0 equal to 1 gives it back. A port reads 8'h00 when it holds the addressed token and 8'hFF otherwise.

Each flag remembers a request from the side that lost. When the holder gives the token back, the token moves straight to the waiting side, so software on that side does not have to poll and retry. All state is updated on the rising clock edge. The read data follows the addressed flag combinationally from the registered state. The asynchronous active-low reset is released in step with the clock.

Top module: `sem_bank`

## Requirements
- R1: The bank has NUM_SEM (default 8) independent flags. The port address picks the flag, and a write to one flag leaves every other flag unchanged.
- R2: A write takes effect only when, on that port, ram_ce_n is 1, sem_n is 0 and we is 1. Any other combination leaves all flags unchanged.
- R3: Only data bit 0 of a write is used. A value of 0 is a request and a value of 1 is a release, and bits 7..1 are ignored.
- R4: A port reads 8'h00 on all data bits when it owns the addressed flag. Otherwise it reads 8'hFF.
- R5: A request on a free flag makes the requesting port the owner. The two ports never own the same flag at once.
- R6: A request by the non-owner while the other side holds the flag changes neither port's read value. The request is recorded as pending.
- R7: When the owner releases a flag that has a pending request, the waiting port becomes the owner on the next cycle.
- R8: When the owner releases a flag with no pending request, the flag becomes free and both ports read 8'hFF.
- R9: A release written by a port that does not own the flag never changes ownership. It cancels that port's own pending request.
- R10: When both ports request the same free flag in the same cycle, the left port becomes the owner and the right request stays pending.
- R11: After reset, every flag is free and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ram_ce_n | input | 1 | Left RAM chip enable, active low; must be 1 to reach the flags |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we | input | 1 | Left write strobe |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left read data for the addressed flag |
| r_ram_ce_n | input | 1 | Right RAM chip enable, active low; must be 1 to reach the flags |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we | input | 1 | Right write strobe |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right read data for the addressed flag |

## Verification
A wrong ownership value shows up on the read data one clock after the write that caused it. A wrong pending bit stays hidden until the holder releases the flag. The bench therefore follows every queued request with a release and checks both ports on the next cycle. It also checks a cancelled request, where a stale pending bit would hand the token to a port that no longer asked for it. The checker tracks ownership and pending state every cycle, so a leak between flags or a simultaneous double grant is caught on the edge where it happens.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } own_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int AW     = $clog2(NUM_SEM)
) (
  input  logic              ram_ce_n,
  input  logic              sem_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SEM-1:0] req,
  output logic [NUM_SEM-1:0] rel
);
  logic wr_ok;
  assign wr_ok = ram_ce_n & ~sem_n & we;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    logic hit;
    assign hit    = wr_ok && (addr == AW'(g));
    assign req[g] = hit & ~wdata[0];
    assign rel[g] = hit &  wdata[0];
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);
  own_e own_q, own_nx;
  logic pl_q, pl_nx, pr_q, pr_nx;
  logic eff_pl, eff_pr, upd;

  assign upd    = req_l | rel_l | req_r | rel_r;
  assign eff_pl = (pl_q | req_l) & ~rel_l;
  assign eff_pr = (pr_q | req_r) & ~rel_r;

  always_comb begin
    own_nx = own_q;
    pl_nx  = pl_q;
    pr_nx  = pr_q;
    case (own_q)
      OWN_NONE: begin
        pl_nx = 1'b0;
        pr_nx = 1'b0;
        if (req_l) begin
          own_nx = OWN_LEFT;
          pr_nx  = req_r;
        end else if (req_r) begin
          own_nx = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        pl_nx = 1'b0;
        if (rel_l) begin
          own_nx = eff_pr ? OWN_RIGHT : OWN_NONE;
          pr_nx  = 1'b0;
        end else begin
          pr_nx = eff_pr;
        end
      end
      OWN_RIGHT: begin
        pr_nx = 1'b0;
        if (rel_r) begin
          own_nx = eff_pl ? OWN_LEFT : OWN_NONE;
          pl_nx  = 1'b0;
        end else begin
          pl_nx = eff_pl;
        end
      end
      default: begin
        own_nx = OWN_NONE;
        pl_nx  = 1'b0;
        pr_nx  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      pl_q  <= 1'b0;
      pr_q  <= 1'b0;
    end else if (upd) begin
      own_q <= own_nx;
      pl_q  <= pl_nx;
      pr_q  <= pr_nx;
    end
  end

  assign own_l  = (own_q == OWN_LEFT);
  assign own_r  = (own_q == OWN_RIGHT);
  assign pend_l = pl_q;
  assign pend_r = pr_q;
endmodule

// File: rtl/sem_rdmux.sv
module sem_rdmux #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int AW     = $clog2(NUM_SEM)
) (
  input  logic [NUM_SEM-1:0] own,
  input  logic [AW-1:0]      addr,
  output logic [DATA_W-1:0]  rdata
);
  logic held;
  always_comb begin
    held = 1'b0;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (addr == AW'(i)) held = own[i];
    end
  end
  assign rdata = {DATA_W{~held}};
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int AW     = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ram_ce_n,
  input  logic              l_sem_n,
  input  logic              l_we,
  input  logic [AW-1:0]     l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_ram_ce_n,
  input  logic              r_sem_n,
  input  logic              r_we,
  input  logic [AW-1:0]     r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic               rst_sync_n;
  logic [NUM_SEM-1:0] req_l_v, rel_l_v, req_r_v, rel_r_v;
  logic [NUM_SEM-1:0] own_l_v, own_r_v, pend_l_v, pend_r_v;

  sem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_l (
    .ram_ce_n(l_ram_ce_n), .sem_n(l_sem_n), .we(l_we), .addr(l_addr),
    .wdata(l_wdata), .req(req_l_v), .rel(rel_l_v)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dec_r (
    .ram_ce_n(r_ram_ce_n), .sem_n(r_sem_n), .we(r_we), .addr(r_addr),
    .wdata(r_wdata), .req(req_r_v), .rel(rel_r_v)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst_n(rst_sync_n),
      .req_l(req_l_v[g]), .rel_l(rel_l_v[g]),
      .req_r(req_r_v[g]), .rel_r(rel_r_v[g]),
      .own_l(own_l_v[g]), .own_r(own_r_v[g]),
      .pend_l(pend_l_v[g]), .pend_r(pend_r_v[g])
    );
  end

  sem_rdmux #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
    .own(own_l_v), .addr(l_addr), .rdata(l_rdata)
  );

  sem_rdmux #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
    .own(own_r_v), .addr(r_addr), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 8,
  localparam int AW     = $clog2(NUM_SEM)
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               l_ram_ce_n,
  input logic               l_sem_n,
  input logic               l_we,
  input logic [AW-1:0]      l_addr,
  input logic [DATA_W-1:0]  l_wdata,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               r_ram_ce_n,
  input logic               r_sem_n,
  input logic               r_we,
  input logic [AW-1:0]      r_addr,
  input logic [DATA_W-1:0]  r_wdata,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] own_l_v,
  input logic [NUM_SEM-1:0] own_r_v,
  input logic [NUM_SEM-1:0] pend_r_v
);
  logic l_acc, r_acc;
  assign l_acc = l_ram_ce_n & ~l_sem_n & l_we;
  assign r_acc = r_ram_ce_n & ~r_sem_n & r_we;

  assert_two_owners_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own_l_v & own_r_v) == '0);

  assert_rdata_form_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l_acc && !r_acc) |=> ($stable(own_l_v) && $stable(own_r_v)));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_chk
    logic lw, rw;
    assign lw = l_acc && (l_addr == AW'(g));
    assign rw = r_acc && (r_addr == AW'(g));

    assert_handover_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (own_l_v[g] && lw && l_wdata[0] && pend_r_v[g] && !rw) |=> own_r_v[g]);

    assert_release_free_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (own_l_v[g] && lw && l_wdata[0] && !pend_r_v[g] && !rw) |=> (!own_l_v[g] && !own_r_v[g]));

    assert_foreign_release_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!own_l_v[g] && lw && l_wdata[0] && !rw) |=> ($stable(own_l_v[g]) && $stable(own_r_v[g])));

    assert_tie_left_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!own_l_v[g] && !own_r_v[g] && lw && !l_wdata[0] && rw && !r_wdata[0])
        |=> (own_l_v[g] && pend_r_v[g]));
  end
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .l_ram_ce_n(l_ram_ce_n), .l_sem_n(l_sem_n), .l_we(l_we), .l_addr(l_addr),
  .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_ram_ce_n(r_ram_ce_n), .r_sem_n(r_sem_n), .r_we(r_we), .r_addr(r_addr),
  .r_wdata(r_wdata), .r_rdata(r_rdata),
  .own_l_v(own_l_v), .own_r_v(own_r_v), .pend_r_v(pend_r_v)
);

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  logic clk = 1'b0;
  logic rst_n;
  logic       l_ram_ce_n, l_sem_n, l_we, r_ram_ce_n, r_sem_n, r_we;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sem_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ram_ce_n(l_ram_ce_n), .l_sem_n(l_sem_n), .l_we(l_we), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_ram_ce_n(r_ram_ce_n), .r_sem_n(r_sem_n), .r_we(r_we), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic idle();
    l_ram_ce_n = 1'b1; l_sem_n = 1'b1; l_we = 1'b0; l_wdata = 8'hFF;
    r_ram_ce_n = 1'b1; r_sem_n = 1'b1; r_we = 1'b0; r_wdata = 8'hFF;
  endtask

  // one write cycle per port; en_x selects which ports write
  task automatic wr(input bit en_l, input logic [2:0] la, input logic [7:0] ld,
                    input bit en_r, input logic [2:0] ra, input logic [7:0] rd);
    @(negedge clk);
    if (en_l) begin l_sem_n = 1'b0; l_we = 1'b1; l_addr = la; l_wdata = ld; end
    if (en_r) begin r_sem_n = 1'b0; r_we = 1'b1; r_addr = ra; r_wdata = rd; end
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string tag, input logic [2:0] a,
                     input logic [7:0] exp_l, input logic [7:0] exp_r);
    l_addr = a; r_addr = a;
    #1;
    n_chk++;
    if (l_rdata !== exp_l || r_rdata !== exp_r) begin
      n_bad++;
      $display("FAIL %s flag %0d: left %h right %h, expected left %h right %h",
               tag, a, l_rdata, r_rdata, exp_l, exp_r);
    end
  endtask

  task automatic do_reset();
    idle();
    l_addr = 3'd0; r_addr = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) chk("R11 reset free", 3'(i), 8'hFF, 8'hFF);
  endtask

  task automatic t_take_queue_pass();
    wr(1, 3'd2, 8'h00, 0, 3'd0, 8'h00);
    chk("R5 left takes free", 3'd2, 8'h00, 8'hFF);
    chk("R1 neighbour untouched", 3'd3, 8'hFF, 8'hFF);
    chk("R4 right no-own reads FF", 3'd2, 8'h00, 8'hFF);
    wr(0, 3'd0, 8'h00, 1, 3'd2, 8'h00);
    chk("R6 queued request invisible", 3'd2, 8'h00, 8'hFF);
    wr(1, 3'd2, 8'h01, 0, 3'd0, 8'h00);
    chk("R7 handover to right", 3'd2, 8'hFF, 8'h00);
    wr(0, 3'd0, 8'h00, 1, 3'd2, 8'h01);
    chk("R8 release to free", 3'd2, 8'hFF, 8'hFF);
  endtask

  task automatic t_foreign_release();
    wr(1, 3'd5, 8'h00, 0, 3'd0, 8'h00);
    wr(0, 3'd0, 8'h00, 1, 3'd5, 8'h01);
    chk("R9 non-owner release ignored", 3'd5, 8'h00, 8'hFF);
    wr(0, 3'd0, 8'h00, 1, 3'd5, 8'h00);
    wr(0, 3'd0, 8'h00, 1, 3'd5, 8'h01);
    wr(1, 3'd5, 8'h01, 0, 3'd0, 8'h00);
    chk("R9 cancelled request not granted", 3'd5, 8'hFF, 8'hFF);
  endtask

  task automatic t_data_bits();
    wr(1, 3'd1, 8'hFE, 0, 3'd0, 8'h00);
    chk("R3 FE acts as request", 3'd1, 8'h00, 8'hFF);
    wr(1, 3'd1, 8'h01, 0, 3'd0, 8'h00);
    chk("R3 01 acts as release", 3'd1, 8'hFF, 8'hFF);
  endtask

  task automatic t_gating();
    @(negedge clk);
    l_sem_n = 1'b1; l_we = 1'b1; l_addr = 3'd4; l_wdata = 8'h00;
    @(negedge clk); idle();
    chk("R2 sem_n high ignored", 3'd4, 8'hFF, 8'hFF);
    @(negedge clk);
    l_ram_ce_n = 1'b0; l_sem_n = 1'b0; l_we = 1'b1; l_addr = 3'd4; l_wdata = 8'h00;
    @(negedge clk); idle();
    chk("R2 ram_ce_n low ignored", 3'd4, 8'hFF, 8'hFF);
    @(negedge clk);
    l_sem_n = 1'b0; l_we = 1'b0; l_addr = 3'd4; l_wdata = 8'h00;
    @(negedge clk); idle();
    chk("R2 read-only access ignored", 3'd4, 8'hFF, 8'hFF);
  endtask

  task automatic t_tie();
    wr(1, 3'd6, 8'h00, 1, 3'd6, 8'h00);
    chk("R10 tie goes left", 3'd6, 8'h00, 8'hFF);
    wr(1, 3'd6, 8'h01, 0, 3'd0, 8'h00);
    chk("R10 right kept pending", 3'd6, 8'hFF, 8'h00);
    wr(1, 3'd7, 8'h00, 1, 3'd0, 8'h00);
    chk("R1 parallel flags left", 3'd7, 8'h00, 8'hFF);
    chk("R1 parallel flags right", 3'd0, 8'hFF, 8'h00);
  endtask

  task automatic t_reset_clears();
    wr(0, 3'd0, 8'h00, 1, 3'd7, 8'h00);
    do_reset();
    t_reset();
    wr(1, 3'd7, 8'h01, 0, 3'd0, 8'h00);
    chk("R11 no pending after reset", 3'd7, 8'hFF, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual hung, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_take_queue_pass();
    t_foreign_release();
    t_data_bits();
    t_gating();
    t_tie();
    t_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule